// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block derives the serial clock of an SPI master from its module clock. A law-select input picks one of two divisor laws. The exponential law takes a 4-bit exponent `E` and gives a serial clock of the module clock shifted right by `E+1`. This law covers the slow end of the range, down to the module clock divided by 65536. The linear law takes an 8-bit count `L` and gives the module clock divided by `2*(L+1)`. This law covers the fast end of the range, up to half the module clock.

The shift engine next to this block asserts `run_i` for as long as a transfer lasts. It uses the two single-cycle strobes to know when the serial clock has just left its idle level and when it has just returned to it. The idle level comes from `cpol_i`. Together with the phase setting held by the shift engine, it gives the four usual SPI modes. The block has no data stream, so it has no valid/ready handshake; every pin is a plain control or status level.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `law_sel_i`=1 (linear), every half period of `sclk_o` lasts `lin_n_i+1` module-clock cycles, so the frequency is the module clock divided by 2*(lin_n_i+1).
- R2: With `law_sel_i`=0 (exponential), every half period lasts 2^`exp_n_i` cycles, so the frequency is the module clock shifted right by exp_n_i+1.
- R3: The extremes of the range are reachable. Linear with `lin_n_i`=0 toggles `sclk_o` on every cycle. Exponential with `exp_n_i`=15 holds each level for 32768 cycles.
- R4: While `run_i` is low, `sclk_o` sits at the `cpol_i` level and both strobes stay low. Reset drives `sclk_o` and both strobes low.
- R5: After `run_i` is first sampled high, the first transition of `sclk_o` lands on the N-th rising edge at which `run_i` is sampled high, where N is the half-period length in cycles.
- R6: A change to `law_sel_i`, `exp_n_i` or `lin_n_i` during a half period does not shorten or lengthen that half period. It applies from the next half period on.
- R7: `lead_stb_o` is high for exactly the one cycle in which `sclk_o` has just left the idle level. `trail_stb_o` is high for exactly the one cycle in which `sclk_o` has just returned to it. The two strobes are never high together.
- R8: With `cpol_i`=1, `sclk_o` idles high and its first transition is falling.
- R9: When `run_i` drops, `sclk_o` goes back to idle on the next edge and the divider restarts. A new run again waits one full half period before its first transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High while the serial clock must toggle |
| law_sel_i | input | 1 | 0 selects the exponential law, 1 the linear law |
| exp_n_i | input | EXP_W | Exponent for the exponential law |
| lin_n_i | input | LIN_W | Count for the linear law |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock, registered |
| lead_stb_o | output | 1 | One-cycle strobe at the edge that leaves idle |
| trail_stb_o | output | 1 | One-cycle strobe at the edge that returns to idle |

## Verification
A wrong half-period counter or a wrong latched terminal count shows at the ports as a half period that is too short or too long. The very first transition after `run_i` rises already shows it, so the error is visible within one half period. A phase register that slips shows as a strobe of the wrong polarity, or as a strobe missing at the change of `sclk_o`, in the same cycle as the transition. A terminal count that follows the fields while a half period is still in progress shows as a half period of irregular length right after a mid-period field change.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic {
    DIV_EXP = 1'b0,
    DIV_LIN = 1'b1
  } div_law_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sclk_div_term.sv
// Converts the selected divisor law into a terminal count (half period - 1).
module sclk_div_term
  import sclk_div_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int LIN_W = 8,
  parameter int CNT_W = 15
) (
  input  div_law_e           law_i,
  input  logic [EXP_W-1:0]   exp_n_i,
  input  logic [LIN_W-1:0]   lin_n_i,
  output logic [CNT_W-1:0]   term_o
);

  // 2^E - 1 is a thermometer code: bit i is set when i < E.
  logic [CNT_W-1:0] thermo;

  for (genvar i = 0; i < CNT_W; i++) begin : g_thermo
    assign thermo[i] = ({1'b0, exp_n_i} > (EXP_W+1)'(i));
  end

  always_comb begin
    if (law_i == DIV_LIN) term_o = CNT_W'(lin_n_i);
    else                  term_o = thermo;
  end

endmodule

// File: rtl/sclk_div_timer.sv
// Half-period timer; the terminal count is relatched only at a boundary.
module sclk_div_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             boundary_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_q;

  assign boundary_o = run_i && (cnt_q == term_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      term_q <= '0;
    end else if (!run_i || boundary_o) begin
      cnt_q  <= '0;
      term_q <= term_i;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term_q);

  // R6
  term_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !boundary_o) |=> $stable(term_q));

  // R9
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/sclk_div_edge.sv
// Phase tracking, registered serial clock and edge strobes.
module sclk_div_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic boundary_i,
  input  logic cpol_i,
  output logic sclk_o,
  output logic lead_stb_o,
  output logic trail_stb_o
);

  logic phase_q;   // 0: idle level, 1: active level
  logic phase_d;

  assign phase_d = run_i ? (phase_q ^ boundary_i) : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= 1'b0;
      sclk_o      <= 1'b0;
      lead_stb_o  <= 1'b0;
      trail_stb_o <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      sclk_o      <= phase_d ^ cpol_i;
      lead_stb_o  <= run_i && boundary_i && !phase_q;
      trail_stb_o <= run_i && boundary_i &&  phase_q;
    end
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_stb_o && trail_stb_o));

  // R7
  change_has_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && (sclk_o != $past(sclk_o))) |-> (lead_stb_o || trail_stb_o));

  // R4
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ((sclk_o == $past(cpol_i)) && !lead_stb_o && !trail_stb_o));

  // R7
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_stb_o |-> !$past(lead_stb_o) || $past(boundary_i));

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int LIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             law_sel_i,
  input  logic [EXP_W-1:0] exp_n_i,
  input  logic [LIN_W-1:0] lin_n_i,
  input  logic             cpol_i,
  output logic             sclk_o,
  output logic             lead_stb_o,
  output logic             trail_stb_o
);

  localparam int CNT_W = max_i((2**EXP_W) - 1, LIN_W);

  logic [CNT_W-1:0] term;
  logic             boundary;

  sclk_div_term #(
    .EXP_W (EXP_W),
    .LIN_W (LIN_W),
    .CNT_W (CNT_W)
  ) u_term (
    .law_i   (div_law_e'(law_sel_i)),
    .exp_n_i (exp_n_i),
    .lin_n_i (lin_n_i),
    .term_o  (term)
  );

  sclk_div_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .term_i     (term),
    .boundary_o (boundary)
  );

  sclk_div_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .boundary_i  (boundary),
    .cpol_i      (cpol_i),
    .sclk_o      (sclk_o),
    .lead_stb_o  (lead_stb_o),
    .trail_stb_o (trail_stb_o)
  );

endmodule

// File: tb/tb_spi_sclk_divider.sv
module tb_spi_sclk_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       law = 1'b0;
  logic [3:0] en = '0;
  logic [7:0] ln = '0;
  logic       cpol = 1'b0;
  logic       sclk, lead, trail;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_sclk_divider dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .law_sel_i(law),
    .exp_n_i(en), .lin_n_i(ln), .cpol_i(cpol),
    .sclk_o(sclk), .lead_stb_o(lead), .trail_stb_o(trail)
  );

  localparam int NV = 6;
  localparam int V_LAW [NV]  = '{1, 1, 1, 0, 0, 0};
  localparam int V_EXP [NV]  = '{0, 0, 0, 0, 3, 9};
  localparam int V_LIN [NV]  = '{0, 5, 255, 0, 0, 0};
  localparam int V_CPOL[NV]  = '{0, 0, 1, 0, 1, 0};
  localparam int V_HALF[NV]  = '{1, 6, 256, 1, 8, 512};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedge samples until sclk changes; flags strobes on steady samples.
  task automatic wait_change(input int cap, output int n, output int stray);
    logic prev;
    prev = sclk;
    n = 0;
    stray = 0;
    while (n < cap) begin
      @(negedge clk);
      n++;
      if (sclk != prev) break;
      if (lead || trail) stray++;
    end
  endtask

  task automatic idle_cycles(input int k);
    run = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n, stray;
    repeat (3) @(negedge clk);
    // R4 reset state
    check(sclk == 1'b0 && !lead && !trail, "R4 reset", int'(sclk), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      law  = V_LAW[v][0];
      en   = 4'(V_EXP[v]);
      ln   = 8'(V_LIN[v]);
      cpol = V_CPOL[v][0];
      idle_cycles(2);
      // R4 / R8 idle level follows cpol
      check(sclk == cpol && !lead && !trail, "R4 R8 idle", int'(sclk), int'(cpol));
      run = 1'b1;
      wait_change(V_HALF[v] + 4, n, stray);
      // R5 first half period; R1/R2/R3 law
      check(n == V_HALF[v], (V_LAW[v] == 1) ? "R5 R1 R3 first half" : "R5 R2 first half",
            n, V_HALF[v]);
      check(sclk == !cpol && lead && !trail && stray == 0, "R7 R8 lead strobe",
            int'({lead, trail}), 2);
      wait_change(V_HALF[v] + 4, n, stray);
      check(n == V_HALF[v], (V_LAW[v] == 1) ? "R1 second half" : "R2 second half",
            n, V_HALF[v]);
      check(sclk == cpol && trail && !lead && stray == 0, "R7 trail strobe",
            int'({lead, trail}), 1);
      run = 1'b0;
      @(negedge clk);
      check(sclk == cpol && !lead && !trail, "R9 stop to idle", int'(sclk), int'(cpol));
    end

    // R6 mid-period change: half 4, switch to half 1 after two samples
    law = 1'b1; ln = 8'd3; cpol = 1'b0;
    idle_cycles(2);
    run = 1'b1;
    @(negedge clk); @(negedge clk);
    ln = 8'd0;
    wait_change(10, n, stray);
    check(n == 2, "R6 current half kept", n, 2);
    wait_change(10, n, stray);
    check(n == 1, "R6 new law at boundary", n, 1);

    // R9 drop run while active, then restart waits a full half period
    ln = 8'd2;
    idle_cycles(2);
    run = 1'b1;
    wait_change(10, n, stray);
    run = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0 && !lead && !trail, "R9 drop while active", int'(sclk), 0);
    run = 1'b1;
    wait_change(10, n, stray);
    check(n == 3 && lead, "R9 restart half", n, 3);

    // R3 slowest setting: exponent 15
    law = 1'b0; en = 4'd15; cpol = 1'b1;
    idle_cycles(2);
    run = 1'b1;
    wait_change(40000, n, stray);
    check(n == 32768 && sclk == 1'b0 && lead && stray == 0, "R3 R2 slowest", n, 32768);
    run = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule